// File: doc/BRIEF.md
# Single-Output Flip Locking Unit

This block wraps a small parameterized sample circuit with key-controlled locking logic. The sample circuit produces several primary outputs from N primary inputs. Exactly one of those outputs, chosen by a parameter, passes through an XOR gate whose second input is a single internal flip signal. No other signal connects the locking logic to the protected circuit.

The flip signal is the AND of two key-mixed functions of the primary inputs. The inputs are XORed with the low key half and fed to an N-input AND; this term is almost always 0. The inputs are also XORed with the high key half and fed to an N-input NAND; this term is almost always 1. When both key halves are equal, the two terms can never be high at the same moment, and the outputs match the unlocked circuit for every input pattern. When the halves differ, the chosen output is inverted for exactly one input pattern, so output corruption under a wrong key is very low.

The unit is purely combinational. N ranges from 4 to 16, and the key is 2N bits wide.

Top module: `flip_lock_unit`

## Requirements
- R1: The unlocked reference is y[k] = x[k] XOR (x[(k+1) mod N] AND x[(k+2) mod N]) for k = 0 .. OUT_W-1. Every output bit other than bit LOCK_SEL equals this reference for every input and key.
- R2: For any key whose low half lock_key[N-1:0] equals its high half lock_key[2N-1:N], output bit LOCK_SEL equals the reference for all 2^N input patterns.
- R3: For a key whose two halves differ, output bit LOCK_SEL differs from the reference for exactly one input pattern out of 2^N.
- R4: The single corrupted pattern under a wrong key is the bitwise inverse of the low key half, lock_key[N-1:0]. Changing only the high half, as long as it stays different from the low half, does not move this pattern.
- R5: On the corrupted pattern, only bit LOCK_SEL is inverted, and it takes the complement of its reference value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_in | input | N | Primary inputs of the sample circuit |
| lock_key | input | 2N | Key; [N-1:0] mixes into the AND term, [2N-1:N] mixes into the NAND term |
| pout | output | OUT_W | Primary outputs; bit LOCK_SEL is the locked one |

## Verification
The block holds no state, so a fault in the key mixing or the AND trees shows up at pout in the same evaluation as the input pattern that triggers it. A fault of this kind either inverts bit LOCK_SEL under a correct key, moves the corrupted pattern away from the inverse of the low key half, or adds or removes corrupted patterns. An exhaustive sweep of all inputs for each chosen key exposes each of these cases. Comparing the other output bits catches damage to the sample circuit, or a flip that was routed to the wrong bit.

// File: rtl/flip_lock_pkg.sv
// Shared helpers for the flip locking unit.
// Assumes: widths passed in are at least 1.
package flip_lock_pkg;

    // Number of binary tree levels needed to reduce w leaves to one node.
    function automatic int unsigned tree_levels(input int unsigned w);
        int unsigned lv;
        lv = 0;
        while ((1 << lv) < w) lv++;
        return lv;
    endfunction

    // Wrap an output index onto the input vector width.
    function automatic int unsigned wrap_idx(input int unsigned i, input int unsigned w);
        return i % w;
    endfunction

endpackage

// File: rtl/lock_key_mix.sv
// Key mixing stage: XORs each primary input bit with one bit of a key half.
// Assumes: the key half and the input vector have the same width W.
module lock_key_mix #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] din,
    input  logic [W-1:0] key_part,
    output logic [W-1:0] dout
);

    // One XOR gate per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[i] ^ key_part[i];
    end

endmodule

// File: rtl/lock_and_tree.sv
// Balanced binary AND reduction. Unused leaves are padded with 1.
// Assumes: W >= 1. Output is 1 only when every input bit is 1.
module lock_and_tree #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] din,
    output logic         dout
);
    import flip_lock_pkg::*;

    localparam int unsigned LEVELS = tree_levels(W);
    localparam int unsigned LEAVES = 1 << LEVELS;

    logic [2*LEAVES-1:1] node;

    // Leaf layer: real inputs, then padding ones.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < W) begin : g_real
            assign node[LEAVES+i] = din[i];
        end else begin : g_pad
            assign node[LEAVES+i] = 1'b1;
        end
    end

    // Internal nodes: each ANDs its two children.
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        assign node[n] = node[2*n] & node[2*n+1];
    end

    assign dout = node[1];

    // Tree result checked against the plain reduction of the inputs.
    always_comb begin
        if (!$isunknown(din)) begin
            assert_tree_reduce_R3: assert (dout == (din == {W{1'b1}}))
                else $error("and tree result wrong");
        end
    end

endmodule

// File: rtl/lock_sample_logic.sv
// Sample protected circuit: y[k] = x[k] ^ (x[k+1] & x[k+2]), indices taken modulo N.
// Assumes: OUT_W <= N.
module lock_sample_logic #(
    parameter int unsigned N     = 8,
    parameter int unsigned OUT_W = 4
) (
    input  logic [N-1:0]     x,
    output logic [OUT_W-1:0] y
);
    import flip_lock_pkg::*;

    // One output bit per generate step.
    for (genvar k = 0; k < OUT_W; k++) begin : g_out
        localparam int unsigned IA = wrap_idx(k + 1, N);
        localparam int unsigned IB = wrap_idx(k + 2, N);
        assign y[k] = x[k] ^ (x[IA] & x[IB]);
    end

endmodule

// File: rtl/flip_lock_unit.sv
// Top of the flip locking unit. The sample circuit output LOCK_SEL is XORed
// with one flip signal: AND(x ^ key_lo) & NAND(x ^ key_hi). Purely combinational.
// Assumes: 4 <= N <= 16, OUT_W <= N, LOCK_SEL < OUT_W.
module flip_lock_unit #(
    parameter int unsigned N        = 8,
    parameter int unsigned OUT_W    = 4,
    parameter int unsigned LOCK_SEL = 2
) (
    input  logic [N-1:0]     pin_in,
    input  logic [2*N-1:0]   lock_key,
    output logic [OUT_W-1:0] pout
);

    localparam int unsigned KEY_W = 2 * N;

    logic [N-1:0]     key_lo;
    logic [N-1:0]     key_hi;
    logic [N-1:0]     mix_lo;
    logic [N-1:0]     mix_hi;
    logic             term_and;
    logic             term_hi_and;
    logic             term_nand;
    logic             flip;
    logic [OUT_W-1:0] plain;

    assign key_lo = lock_key[N-1:0];
    assign key_hi = lock_key[KEY_W-1:N];

    // Protected circuit.
    lock_sample_logic #(.N(N), .OUT_W(OUT_W)) u_core (
        .x (pin_in),
        .y (plain)
    );

    // Key mixing for the function skewed towards 0.
    lock_key_mix #(.W(N)) u_mix_lo (
        .din      (pin_in),
        .key_part (key_lo),
        .dout     (mix_lo)
    );

    // Key mixing for the complementary function skewed towards 1.
    lock_key_mix #(.W(N)) u_mix_hi (
        .din      (pin_in),
        .key_part (key_hi),
        .dout     (mix_hi)
    );

    // AND term, high for one pattern only.
    lock_and_tree #(.W(N)) u_tree_lo (
        .din  (mix_lo),
        .dout (term_and)
    );

    // AND of the other mixed vector, inverted below to form the NAND term.
    lock_and_tree #(.W(N)) u_tree_hi (
        .din  (mix_hi),
        .dout (term_hi_and)
    );

    // Complementary term and the single flip signal.
    assign term_nand = ~term_hi_and;
    assign flip      = term_and & term_nand;

    // Output stage: only the selected bit sees the flip signal.
    for (genvar j = 0; j < OUT_W; j++) begin : g_pout
        if (j == LOCK_SEL) begin : g_locked
            assign pout[j] = plain[j] ^ flip;
        end else begin : g_pass
            assign pout[j] = plain[j];
        end
    end

    // Port-level relations between inputs, key and outputs.
    always_comb begin
        if (!$isunknown({pin_in, lock_key})) begin
            // R1: no bit other than LOCK_SEL ever differs from the sample circuit.
            assert_other_bits_R1: assert (((pout ^ plain) & ~(OUT_W'(1) << LOCK_SEL)) == '0)
                else $error("non-target output disturbed");
            // R2: equal key halves never corrupt the output.
            if (key_lo == key_hi) begin
                assert_correct_key_R2: assert (pout == plain)
                    else $error("corruption under correct key");
            end
            // R4: corruption only on the inverse of the low key half.
            if (pout != plain) begin
                assert_pattern_R4: assert (pin_in == ~key_lo)
                    else $error("corruption on unexpected pattern");
            end
            // R3: the NAND term is high away from the inverse of the high key half.
            if (pin_in != ~key_hi) begin
                assert_nand_skew_R3: assert (term_nand)
                    else $error("NAND term low on common pattern");
            end
            // R5: on the trigger pattern with differing halves the bit is inverted.
            if (pin_in == ~key_lo && key_lo != key_hi) begin
                assert_invert_R5: assert (pout[LOCK_SEL] != plain[LOCK_SEL])
                    else $error("target bit not inverted");
            end
        end
    end

endmodule

// File: tb/test_flip_lock_unit.sv
// Exhaustive bench: for each chosen key, sweeps every input pattern and compares
// pout with a behavioural model of the unlocked circuit plus the expected flip.
module test_flip_lock_unit;

    localparam int N        = 8;
    localparam int OUT_W    = 4;
    localparam int LOCK_SEL = 2;
    localparam int PATS     = 1 << N;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     pin_in = '0;
    logic [2*N-1:0]   lock_key = '0;
    logic [OUT_W-1:0] pout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flip_lock_unit #(.N(N), .OUT_W(OUT_W), .LOCK_SEL(LOCK_SEL)) i_flip_lock_unit (
        .pin_in   (pin_in),
        .lock_key (lock_key),
        .pout     (pout)
    );

    // Behavioural reference of the unlocked sample circuit (R1 formula).
    function automatic logic [OUT_W-1:0] ref_out(input logic [N-1:0] x);
        logic [OUT_W-1:0] r;
        for (int k = 0; k < OUT_W; k++)
            r[k] = x[k] ^ (x[(k+1)%N] & x[(k+2)%N]);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sweep all inputs for one key; returns mismatches on the target bit and the last trigger.
    task automatic sweep(input logic [N-1:0] klo, input logic [N-1:0] khi,
                         output int nbad, output int where);
        logic [OUT_W-1:0] mask;
        mask = ~(OUT_W'(1) << LOCK_SEL);
        nbad = 0;
        where = -1;
        for (int p = 0; p < PATS; p++) begin
            @(posedge clk);
            pin_in   <= N'(p);
            lock_key <= {khi, klo};
            @(negedge clk);
            begin
                logic [OUT_W-1:0] r;
                logic             hit;
                r = ref_out(N'(p));
                hit = (N'(p) == ~klo) && (klo != khi);
                // R1: non-target bits track the reference.
                check("R1", 32'(pout & mask), 32'(r & mask));
                // R5: target bit is the reference, inverted only on the trigger pattern.
                check("R5", 32'(pout[LOCK_SEL]), 32'(r[LOCK_SEL] ^ hit));
                if (pout[LOCK_SEL] !== r[LOCK_SEL]) begin
                    nbad++;
                    where = p;
                end
            end
        end
    endtask

    initial begin : stim
        int nb;
        int wh;
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // Idle state: zero inputs and zero key give the reference output.
        check("R2", 32'(pout), 32'(ref_out('0)));

        // R2: correct keys, halves equal.
        sweep(8'h00, 8'h00, nb, wh); check("R2", nb, 0);
        sweep(8'hA5, 8'hA5, nb, wh); check("R2", nb, 0);
        sweep(8'hFF, 8'hFF, nb, wh); check("R2", nb, 0);

        // R3 and R4: wrong keys, one corrupted pattern at ~key_lo.
        sweep(8'h3C, 8'h00, nb, wh); check("R3", nb, 1); check("R4", wh, 32'h00C3);
        sweep(8'h3C, 8'hF1, nb, wh); check("R3", nb, 1); check("R4", wh, 32'h00C3);
        sweep(8'h00, 8'h01, nb, wh); check("R3", nb, 1); check("R4", wh, 32'h00FF);
        sweep(8'hFF, 8'h7F, nb, wh); check("R3", nb, 1); check("R4", wh, 32'h0000);
        // R4 with the trigger on a pattern where the reference bit is 1.
        sweep(8'h13, 8'h31, nb, wh); check("R3", nb, 1); check("R4", wh, 32'h00EC);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule